// File: doc/BRIEF.md
# Uncorrectable Error Header Logger With Pending Record Queue

This block records which uncorrectable error came first and keeps the details captured with it: a pointer to the status bit, four words of the offending packet header and four words of its end-to-end prefix. It also owns the uncorrectable error status vector. Requests set status bits, and software clears them by writing ones.

When multiple header recording is turned on, errors that arrive while the first one is still outstanding are placed in a circular queue of depth `QDEPTH`. They are not allowed to overwrite the log. When software clears the status bit that the pointer names, the block sets the status bits of every pending record again and moves the oldest pending record into the log. If software clears a pending record's status bit too early, the block sets it again. If recording is off, or the queue is empty, clearing the pointed-to bit empties the log.

Error classification, masking and message generation happen upstream. A request reaches this block only for an error that is to be logged.

Top module: `first_err_log`

## Requirements
- R1: A logged request loads `first_ptr` with the bit index of the single set bit of `log_status`.
- R2: Word i of `hdr_log` is word i of the logged header with its four bytes reversed (word i occupies bits [32i+31:32i]). When the record's header-valid flag is 0, `hdr_log` is all zero.
- R3: The prefix log is loaded with the byte-reversed prefix words, and `pfx_logged` is set, only when the record has a prefix and `prefix_supported` is 1 at load time. Otherwise `pfx_log` is zero and `pfx_logged` is 0.
- R4: Consider a request that arrives while recording is active and the status bit at `first_ptr` is set. It is queued, and the log stays unchanged. If the queue holds `QDEPTH` records, the record is dropped and `overflow` is high for exactly one cycle. In both cases the request's status bit is set.
- R5: Consider a status write after which the bit at `first_ptr` is 0, with recording inactive or the queue empty. After it, `first_ptr`, `pfx_logged`, `hdr_log` and `pfx_log` are zero.
- R6: Consider a status write after which the bit at `first_ptr` is 0, with pending records queued. The status bits of all pending records are set again, and the oldest record is loaded into the log as in R1 to R3.
- R7: Consider a status write that leaves the bit at `first_ptr` set while recording is active. The status bits of all pending records are set again, so early clears have no effect.
- R8: Any status write while recording is inactive discards every pending record.
- R9: `mh_capable` is 1 exactly when `QDEPTH` > 0. Recording is active only when `multi_en` is 1 and `mh_capable` is 1. While recording is inactive, every request overwrites the log.
- R10: Reset clears all outputs and the queue. When a write and a request occur in the same cycle, the write takes effect first and the request is then handled against the result. A status bit clears only through a write of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| multi_en | input | 1 | Software enable for multiple header recording |
| prefix_supported | input | 1 | End-to-end prefix support is advertised |
| log_req | input | 1 | Log request strobe |
| log_status | input | NUM_BITS | One-hot status bit of the request |
| log_hdr | input | WORD_W*NWORDS | Header words, word i at bits [32i+31:32i] |
| log_pfx | input | WORD_W*NWORDS | Prefix words, same layout |
| log_hdr_valid | input | 1 | Request carries a valid header |
| log_pfx_present | input | 1 | Request carries a prefix |
| sw_wr | input | 1 | Software write-1-to-clear strobe for status |
| sw_wdata | input | NUM_BITS | Bits to clear |
| first_ptr | output | $clog2(NUM_BITS) | First-error pointer |
| pfx_logged | output | 1 | Prefix log holds a valid prefix |
| hdr_log | output | WORD_W*NWORDS | Header log, byte-reversed words |
| pfx_log | output | WORD_W*NWORDS | Prefix log, byte-reversed words |
| unc_status | output | NUM_BITS | Uncorrectable error status |
| overflow | output | 1 | One-cycle pulse when a record is dropped |
| mh_capable | output | 1 | Multiple header recording capability |

## Verification
The checker watches several invariants on every cycle:
- the queue count stays within its depth;
- a non-empty queue implies the pointed-to status bit is set;
- a status bit never falls without a write;
- `overflow` follows only a request;
- the log is stable in idle cycles;
- the prefix log is zero whenever `pfx_logged` is low.

Some behaviours only the bench's scenarios can show: the byte ordering of the logs, the oldest-first pop order, restoration of early-cleared bits, and flushing when recording is off. A flush is made visible by later clearing the first error and observing that nothing is popped. The bench also covers the result of a same-cycle write and request.

// File: rtl/first_err_log.sv
module first_err_log #(
  parameter int NUM_BITS = 32,
  parameter int WORD_W   = 32,
  parameter int NWORDS   = 4,
  parameter int QDEPTH   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       multi_en,
  input  logic                       prefix_supported,
  input  logic                       log_req,
  input  logic [NUM_BITS-1:0]        log_status,
  input  logic [WORD_W*NWORDS-1:0]   log_hdr,
  input  logic [WORD_W*NWORDS-1:0]   log_pfx,
  input  logic                       log_hdr_valid,
  input  logic                       log_pfx_present,
  input  logic                       sw_wr,
  input  logic [NUM_BITS-1:0]        sw_wdata,
  output logic [$clog2(NUM_BITS)-1:0] first_ptr,
  output logic                       pfx_logged,
  output logic [WORD_W*NWORDS-1:0]   hdr_log,
  output logic [WORD_W*NWORDS-1:0]   pfx_log,
  output logic [NUM_BITS-1:0]        unc_status,
  output logic                       overflow,
  output logic                       mh_capable
);
  localparam int IDX_W  = $clog2(NUM_BITS);
  localparam int REC_W  = WORD_W * NWORDS;
  localparam int NBYTES = WORD_W / 8;
  localparam int QSLOTS = (QDEPTH > 0) ? QDEPTH : 1;
  localparam int QAW    = (QSLOTS > 1) ? $clog2(QSLOTS) : 1;
  localparam int CNT_W  = $clog2(QSLOTS + 1);

  function automatic logic [REC_W-1:0] be_words(input logic [REC_W-1:0] v);
    logic [REC_W-1:0] r;
    r = '0;
    for (int w = 0; w < NWORDS; w++)
      for (int b = 0; b < NBYTES; b++)
        r[w*WORD_W + b*8 +: 8] = v[w*WORD_W + (NBYTES-1-b)*8 +: 8];
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] low_index(input logic [NUM_BITS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_BITS - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [QAW-1:0] bump(input logic [QAW-1:0] p);
    return (int'(p) == QSLOTS - 1) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0] q_idx [QSLOTS];
  logic [REC_W-1:0] q_hdr [QSLOTS];
  logic [REC_W-1:0] q_pfx [QSLOTS];
  logic             q_hv  [QSLOTS];
  logic             q_pp  [QSLOTS];
  logic [QAW-1:0]   head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  logic [NUM_BITS-1:0] status_q, st_w, queued_or;
  logic [IDX_W-1:0]    fep_q, fep_w;
  logic                mh_on, pop, flush, clr_log, push, drop, req_ld;
  logic [CNT_W-1:0]    cnt_w;

  assign mh_capable = (QDEPTH > 0);
  assign mh_on      = multi_en && (QDEPTH > 0);
  assign unc_status = status_q;
  assign first_ptr  = fep_q;

  always_comb begin
    queued_or = '0;
    for (int k = 0; k < QSLOTS; k++) begin
      int s;
      s = int'(head_q) + k;
      if (s >= QSLOTS) s = s - QSLOTS;
      if (k < int'(count_q)) queued_or[q_idx[QAW'(s)]] = 1'b1;
    end
  end

  always_comb begin
    st_w    = status_q;
    fep_w   = fep_q;
    pop     = 1'b0;
    flush   = sw_wr && !mh_on;
    clr_log = 1'b0;
    if (sw_wr) begin
      st_w = status_q & ~sw_wdata;
      if (!st_w[fep_q]) begin
        if (!mh_on || count_q == '0) begin
          clr_log = 1'b1;
          fep_w   = '0;
        end else begin
          st_w  = st_w | queued_or;
          pop   = 1'b1;
          fep_w = q_idx[head_q];
        end
      end else if (mh_on) begin
        st_w = st_w | queued_or;
      end
    end
    cnt_w  = count_q - CNT_W'(pop);
    push   = 1'b0;
    drop   = 1'b0;
    req_ld = 1'b0;
    if (log_req) begin
      if (mh_on && st_w[fep_w]) begin
        if (cnt_w == CNT_W'(QDEPTH)) drop = 1'b1;
        else push = 1'b1;
      end else begin
        req_ld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q   <= '0;
      fep_q      <= '0;
      hdr_log    <= '0;
      pfx_log    <= '0;
      pfx_logged <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      status_q <= st_w | (log_req ? log_status : '0);
      overflow <= drop;
      if (req_ld) begin
        fep_q      <= low_index(log_status);
        hdr_log    <= log_hdr_valid ? be_words(log_hdr) : '0;
        pfx_logged <= log_pfx_present && prefix_supported;
        pfx_log    <= (log_pfx_present && prefix_supported) ? be_words(log_pfx) : '0;
      end else if (pop) begin
        fep_q      <= q_idx[head_q];
        hdr_log    <= q_hv[head_q] ? be_words(q_hdr[head_q]) : '0;
        pfx_logged <= q_pp[head_q] && prefix_supported;
        pfx_log    <= (q_pp[head_q] && prefix_supported) ? be_words(q_pfx[head_q]) : '0;
      end else if (clr_log) begin
        fep_q      <= '0;
        hdr_log    <= '0;
        pfx_log    <= '0;
        pfx_logged <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (flush) begin
      tail_q  <= head_q;
      count_q <= '0;
    end else begin
      if (push) tail_q <= bump(tail_q);
      if (pop)  head_q <= bump(head_q);
      count_q <= cnt_w + CNT_W'(push);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_idx[tail_q] <= low_index(log_status);
      q_hdr[tail_q] <= log_hdr;
      q_pfx[tail_q] <= log_pfx;
      q_hv[tail_q]  <= log_hdr_valid;
      q_pp[tail_q]  <= log_pfx_present;
    end
  end
endmodule

// File: rtl/first_err_log_chk.sv
module first_err_log_chk #(
  parameter int NUM_BITS = 32,
  parameter int REC_W    = 128,
  parameter int QDEPTH   = 4,
  parameter int CNT_W    = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        log_req,
  input logic [NUM_BITS-1:0]         log_status,
  input logic                        sw_wr,
  input logic [$clog2(NUM_BITS)-1:0] first_ptr,
  input logic                        pfx_logged,
  input logic [REC_W-1:0]            hdr_log,
  input logic [REC_W-1:0]            pfx_log,
  input logic [NUM_BITS-1:0]         unc_status,
  input logic                        overflow,
  input logic [CNT_W-1:0]            count_q
);
  p_onehot_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> $onehot(log_status));

  p_pfx_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_logged |-> (pfx_log == '0));

  p_count_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= QDEPTH);

  p_ovf_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(log_req));

  p_log_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(log_req) && !$past(sw_wr)) |-> ($stable(hdr_log) && $stable(first_ptr)));

  p_queue_first_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != '0) |-> unc_status[first_ptr]);

  p_clear_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((~unc_status & $past(unc_status)) != '0) |-> $past(sw_wr));
endmodule

bind first_err_log first_err_log_chk #(
  .NUM_BITS(NUM_BITS), .REC_W(REC_W), .QDEPTH(QDEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .log_req(log_req), .log_status(log_status),
  .sw_wr(sw_wr), .first_ptr(first_ptr), .pfx_logged(pfx_logged),
  .hdr_log(hdr_log), .pfx_log(pfx_log), .unc_status(unc_status),
  .overflow(overflow), .count_q(count_q)
);

// File: tb/first_err_log_bench.sv
`timescale 1ns/100ps
module first_err_log_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         multi_en = 1'b1, prefix_supported = 1'b1;
  logic         log_req = 1'b0, log_hdr_valid = 1'b0, log_pfx_present = 1'b0;
  logic [31:0]  log_status = '0, sw_wdata = '0;
  logic [127:0] log_hdr = '0, log_pfx = '0;
  logic         sw_wr = 1'b0;
  logic [4:0]   first_ptr;
  logic         pfx_logged, overflow, mh_capable;
  logic [127:0] hdr_log, pfx_log;
  logic [31:0]  unc_status;
  int           n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  first_err_log u_first_err_log (
    .clk(clk), .rst_n(rst_n), .multi_en(multi_en), .prefix_supported(prefix_supported),
    .log_req(log_req), .log_status(log_status), .log_hdr(log_hdr), .log_pfx(log_pfx),
    .log_hdr_valid(log_hdr_valid), .log_pfx_present(log_pfx_present),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .first_ptr(first_ptr), .pfx_logged(pfx_logged),
    .hdr_log(hdr_log), .pfx_log(pfx_log), .unc_status(unc_status),
    .overflow(overflow), .mh_capable(mh_capable));

  typedef struct packed {
    logic        wr;
    logic [4:0]  idx;
    logic [3:0]  seed;
    logic        hv;
    logic        pp;
    logic [31:0] mask;
    logic [4:0]  efep;
    logic [31:0] estat;
    logic [3:0]  ehs;
    logic [3:0]  eps;
    logic        epl;
    logic        eovf;
  } vec_t;

  localparam vec_t TBL [14] = '{
    '{1'b0, 5'd4,  4'd1, 1'b1, 1'b1, 32'h0,    5'd4,  32'h10,   4'd1, 4'd1, 1'b1, 1'b0},
    '{1'b0, 5'd12, 4'd2, 1'b1, 1'b0, 32'h0,    5'd4,  32'h1010, 4'd1, 4'd1, 1'b1, 1'b0},
    '{1'b0, 5'd5,  4'd3, 1'b0, 1'b1, 32'h0,    5'd4,  32'h1030, 4'd1, 4'd1, 1'b1, 1'b0},
    '{1'b1, 5'd0,  4'd0, 1'b0, 1'b0, 32'h1000, 5'd4,  32'h1030, 4'd1, 4'd1, 1'b1, 1'b0},
    '{1'b1, 5'd0,  4'd0, 1'b0, 1'b0, 32'h10,   5'd12, 32'h1020, 4'd2, 4'd0, 1'b0, 1'b0},
    '{1'b1, 5'd0,  4'd0, 1'b0, 1'b0, 32'h1000, 5'd5,  32'h20,   4'd0, 4'd3, 1'b1, 1'b0},
    '{1'b1, 5'd0,  4'd0, 1'b0, 1'b0, 32'h20,   5'd0,  32'h0,    4'd0, 4'd0, 1'b0, 1'b0},
    '{1'b0, 5'd7,  4'd4, 1'b1, 1'b0, 32'h0,    5'd7,  32'h80,   4'd4, 4'd0, 1'b0, 1'b0},
    '{1'b0, 5'd8,  4'd5, 1'b1, 1'b0, 32'h0,    5'd7,  32'h180,  4'd4, 4'd0, 1'b0, 1'b0},
    '{1'b0, 5'd9,  4'd6, 1'b1, 1'b0, 32'h0,    5'd7,  32'h380,  4'd4, 4'd0, 1'b0, 1'b0},
    '{1'b0, 5'd10, 4'd7, 1'b1, 1'b0, 32'h0,    5'd7,  32'h780,  4'd4, 4'd0, 1'b0, 1'b0},
    '{1'b0, 5'd11, 4'd8, 1'b1, 1'b0, 32'h0,    5'd7,  32'hF80,  4'd4, 4'd0, 1'b0, 1'b0},
    '{1'b0, 5'd13, 4'd9, 1'b1, 1'b0, 32'h0,    5'd7,  32'h2F80, 4'd4, 4'd0, 1'b0, 1'b1},
    '{1'b1, 5'd0,  4'd0, 1'b0, 1'b0, 32'h80,   5'd8,  32'h2F00, 4'd5, 4'd0, 1'b0, 1'b0}
  };

  function automatic logic [127:0] mk(input logic [3:0] seed, input logic kind);
    logic [127:0] r;
    for (int i = 0; i < 4; i++)
      r[i*32 +: 32] = {kind ? 8'hD1 : 8'hC0, 4'h0, seed, 8'(i), 8'h5A};
    return r;
  endfunction

  function automatic logic [127:0] swp(input logic [127:0] v);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = v[i*32 +: 32];
      r[i*32 +: 32] = {w[7:0], w[15:8], w[23:16], w[31:24]};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [4:0] efep, input logic [31:0] estat,
                       input logic [3:0] ehs, input logic [3:0] eps, input logic epl,
                       input logic eovf);
    logic [127:0] eh, ep;
    eh = (ehs == 0) ? '0 : swp(mk(ehs, 1'b0));
    ep = (eps == 0) ? '0 : swp(mk(eps, 1'b1));
    n_chk++;
    if (first_ptr !== efep || unc_status !== estat || hdr_log !== eh || pfx_log !== ep ||
        pfx_logged !== epl || overflow !== eovf) begin
      n_bad++;
      $display("FAIL %s: ptr=%0d/%0d status=%h/%h hdr=%h/%h pfx=%h/%h present=%b/%b ovf=%b/%b",
               req, first_ptr, efep, unc_status, estat, hdr_log, eh, pfx_log, ep,
               pfx_logged, epl, overflow, eovf);
    end
  endtask

  task automatic step(input logic wr, input logic [31:0] mask, input logic req,
                      input logic [4:0] idx, input logic [3:0] seed, input logic hv,
                      input logic pp);
    @(negedge clk);
    sw_wr = wr; sw_wdata = mask;
    log_req = req; log_status = req ? (32'd1 << idx) : '0;
    log_hdr = mk(seed, 1'b0); log_pfx = mk(seed, 1'b1);
    log_hdr_valid = hv; log_pfx_present = pp;
    @(negedge clk);
    sw_wr = 1'b0; log_req = 1'b0; log_status = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset", 5'd0, 32'h0, 4'd0, 4'd0, 1'b0, 1'b0);

    // R1 R2 R3 R4 R5 R6 R7 through the vector table
    for (int i = 0; i < 14; i++) begin
      step(TBL[i].wr, TBL[i].mask, !TBL[i].wr, TBL[i].idx, TBL[i].seed, TBL[i].hv, TBL[i].pp);
      check($sformatf("R1-R7 vector %0d", i), TBL[i].efep, TBL[i].estat, TBL[i].ehs,
            TBL[i].eps, TBL[i].epl, TBL[i].eovf);
    end

    // R8: write with recording off leaves pointer but discards queue
    multi_en = 1'b0;
    step(1'b1, 32'h2000, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    check("R8 flush keeps log", 5'd8, 32'h0F00, 4'd5, 4'd0, 1'b0, 1'b0);
    multi_en = 1'b1;
    step(1'b1, 32'h100, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    check("R8 nothing popped after flush", 5'd0, 32'h0E00, 4'd0, 4'd0, 1'b0, 1'b0);
    step(1'b1, 32'hE00, 1'b0, 5'd0, 4'd0, 1'b0, 1'b0);
    check("R5 clear empty", 5'd0, 32'h0, 4'd0, 4'd0, 1'b0, 1'b0);

    // R3: prefix not supported
    prefix_supported = 1'b0;
    step(1'b0, 32'h0, 1'b1, 5'd3, 4'd10, 1'b1, 1'b1);
    check("R3 prefix unsupported", 5'd3, 32'h8, 4'd10, 4'd0, 1'b0, 1'b0);
    prefix_supported = 1'b1;

    // R10: write and request in the same cycle
    step(1'b1, 32'h8, 1'b1, 5'd6, 4'd11, 1'b1, 1'b1);
    check("R10 write then request", 5'd6, 32'h40, 4'd11, 4'd11, 1'b1, 1'b0);

    // R9: recording off overwrites the log
    multi_en = 1'b0;
    step(1'b0, 32'h0, 1'b1, 5'd9, 4'd12, 1'b0, 1'b0);
    check("R9 overwrite when off", 5'd9, 32'h240, 4'd0, 4'd0, 1'b0, 1'b0);

    n_chk++;
    if (mh_capable !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 capability: actual=%b expected=1", mh_capable);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule